// File: doc/BRIEF.md
# One-Pass CRC Frame Checker

This block sits on the receive side of a byte-wide link. It runs a CRC over every byte of a frame, the trailing transmitted check field included, and never separates the payload from that field. When the last byte has been absorbed, it compares the raw CRC register with a fixed residue. A correct frame always leaves the same value there. The block reports the result as a one-cycle good or bad pulse.

Parameters set the following:
- the register width;
- the generator polynomial, written in the normal high-bit-first form;
- the bit order inside each byte;
- the preset value;
- the residue to expect.

With no output inversion the residue is zero, whatever the preset. With an output inversion it is a fixed non-zero constant, which can be found by running any known-good frame through the block.

The register holds a valid intermediate remainder after every byte. The block therefore needs no warning that a frame is about to end, and no knowledge of where the check field begins. The upstream framer supplies a start strobe and an end strobe on the beats that carry the first and last bytes.

Top module: `crc_frame_checker`

## Requirements
- R1: After reset both verdict outputs are low. The register holds the preset, so a frame whose first beat carries no start strobe is still checked from the preset.
- R2: With the default parameters, a frame ends with its 4-byte check field sent least significant byte first. That field is the inverted register value, where the register uses polynomial 0x04C11DB7 in reflected form, least significant bit of each byte first, and an all-ones preset. For such a frame, frame_good is high for exactly the cycle after the clock edge that took the end beat. The raw register then equals 0xDEBB20E3.
- R3: Any frame whose raw register after its end beat differs from the residue gives frame_bad in the cycle after that end beat, for example a frame with one byte altered.
- R4: A verdict appears only in the cycle after a valid end beat. frame_good and frame_bad are never high together, and each falls after one cycle unless another end beat follows at once.
- R5: A valid beat with the start strobe reloads the preset before its byte is absorbed. Any bytes taken before it have no effect on the verdict.
- R6: A beat with in_valid low changes neither the register nor the outputs, whatever its data, start and end strobes carry.
- R7: A one-byte frame, with the start and end strobes on the same valid beat, is checked on its own.
- R8: With the most-significant-bit-first order and no output inversion, the residue is zero for any preset. A 16-bit variant using polynomial 0x1021 and preset 0xFFFF, with its check field sent high byte first, reports good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte and strobes on this cycle are meaningful |
| in_sof | input | 1 | This beat carries the first byte of a frame |
| in_eof | input | 1 | This beat carries the last byte of a frame |
| in_data | input | 8 | Received byte |
| frame_good | output | 1 | One-cycle pulse: the finished frame matched the residue |
| frame_bad | output | 1 | One-cycle pulse: the finished frame did not match |

## Verification
The register absorbs a byte at the rising edge that samples its beat. The verdict flop is loaded at that same edge from the updated remainder, so a result is due exactly one cycle after its end beat. The bench drives each beat at a falling edge and predicts both verdict bits for the following cycle from a bit-serial model. It compares them at the next falling edge, so every clock is checked against a value that has had exactly one register stage to settle. Two instances, reflected CRC-32 and high-bit-first 16-bit, are each checked every cycle, including the cycles in which they are idle.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

    typedef enum logic {
        BIT_ORDER_MSB = 1'b0,
        BIT_ORDER_LSB = 1'b1
    } bit_order_e;

    typedef struct packed {
        logic good;
        logic bad;
    } verdict_t;

    localparam int MAX_CRC_W = 64;

    // Mirror the low w bits of v; used to turn a normal polynomial into its reflected form.
    function automatic logic [MAX_CRC_W-1:0] rev_bits(input logic [MAX_CRC_W-1:0] v, input int w);
        logic [MAX_CRC_W-1:0] r;
        r = '0;
        for (int i = 0; i < w; i++) begin
            r[i] = v[w-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
    import crc_chk_pkg::*;
#(
    parameter int         W     = 32,
    parameter logic [W-1:0] POLY  = 32'h04C11DB7,
    parameter bit_order_e ORDER = BIT_ORDER_LSB
) (
    input  logic [W-1:0] crc_in,
    input  logic [7:0]   data,
    output logic [W-1:0] crc_out
);
    localparam logic [W-1:0] REFL_POLY = W'(rev_bits(MAX_CRC_W'(POLY), W));

    generate
        if (ORDER == BIT_ORDER_LSB) begin : g_lsb_first
            always_comb begin
                logic [W-1:0] c;
                logic         fb;
                c = crc_in;
                for (int i = 0; i < 8; i++) begin
                    fb = c[0] ^ data[i];
                    c  = {1'b0, c[W-1:1]};
                    if (fb) c = c ^ REFL_POLY;
                end
                crc_out = c;
            end
        end else begin : g_msb_first
            always_comb begin
                logic [W-1:0] c;
                logic         fb;
                c = crc_in;
                for (int i = 7; i >= 0; i--) begin
                    fb = c[W-1] ^ data[i];
                    c  = {c[W-2:0], 1'b0};
                    if (fb) c = c ^ POLY;
                end
                crc_out = c;
            end
        end
    endgenerate
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
    parameter int           W      = 32,
    parameter logic [W-1:0] PRESET = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic         sof,
    input  logic [W-1:0] crc_next,
    output logic [W-1:0] crc_base
);
    logic [W-1:0] crc_q;

    // A start beat folds its byte into the preset rather than the old remainder.
    assign crc_base = (valid && sof) ? PRESET : crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= PRESET;
        end else if (valid) begin
            crc_q <= crc_next;
        end
    end

    a_r6_hold_state: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(crc_q));
endmodule

// File: rtl/crc_verdict.sv
module crc_verdict
    import crc_chk_pkg::*;
#(
    parameter int           W       = 32,
    parameter logic [W-1:0] RESIDUE = 32'hDEBB20E3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic [W-1:0] crc_next,
    output verdict_t     verdict
);
    logic match;
    assign match = (crc_next == RESIDUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.good <= fire && match;
            verdict.bad  <= fire && !match;
        end
    end

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(verdict.good && verdict.bad));
    a_r4_only_after_eof: assert property (@(posedge clk) disable iff (rst)
        (verdict.good || verdict.bad) |-> $past(fire));
    a_r2_verdict_due: assert property (@(posedge clk) disable iff (rst)
        fire |=> (verdict.good || verdict.bad));
endmodule

// File: rtl/crc_frame_checker.sv
module crc_frame_checker
    import crc_chk_pkg::*;
#(
    parameter int           W       = 32,
    parameter logic [W-1:0] POLY    = 32'h04C11DB7,
    parameter bit_order_e   ORDER   = BIT_ORDER_LSB,
    parameter logic [W-1:0] PRESET  = '1,
    parameter logic [W-1:0] RESIDUE = 32'hDEBB20E3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    output logic       frame_good,
    output logic       frame_bad
);
    logic [W-1:0] crc_base;
    logic [W-1:0] crc_next;
    verdict_t     verdict;

    crc_state_reg #(.W(W), .PRESET(PRESET)) u_state (
        .clk      (clk),
        .rst      (rst),
        .valid    (in_valid),
        .sof      (in_sof),
        .crc_next (crc_next),
        .crc_base (crc_base)
    );

    crc_byte_engine #(.W(W), .POLY(POLY), .ORDER(ORDER)) u_engine (
        .crc_in  (crc_base),
        .data    (in_data),
        .crc_out (crc_next)
    );

    crc_verdict #(.W(W), .RESIDUE(RESIDUE)) u_verdict (
        .clk      (clk),
        .rst      (rst),
        .fire     (in_valid && in_eof),
        .crc_next (crc_next),
        .verdict  (verdict)
    );

    assign frame_good = verdict.good;
    assign frame_bad  = verdict.bad;

    a_r6_no_verdict: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(frame_good || frame_bad));
endmodule

// File: tb/test_crc_frame_checker.sv
module test_crc_frame_checker;
    import crc_chk_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       v [2];
    logic       s [2];
    logic       e [2];
    logic [7:0] d [2];
    logic       good [2];
    logic       bad  [2];

    crc_frame_checker i_crc_frame_checker (
        .clk(clk), .rst(rst), .in_valid(v[0]), .in_sof(s[0]), .in_eof(e[0]),
        .in_data(d[0]), .frame_good(good[0]), .frame_bad(bad[0]));

    crc_frame_checker #(
        .W(16), .POLY(16'h1021), .ORDER(BIT_ORDER_MSB),
        .PRESET(16'hFFFF), .RESIDUE(16'h0000)
    ) i_crc_frame_checker_msb (
        .clk(clk), .rst(rst), .in_valid(v[1]), .in_sof(s[1]), .in_eof(e[1]),
        .in_data(d[1]), .frame_good(good[1]), .frame_bad(bad[1]));

    int checks = 0;
    int failures = 0;

    logic [31:0] mreg [2];
    logic        xg [2];
    logic        xb [2];
    string       xtag [2];

    function automatic int wid(int sel);       return sel == 0 ? 32 : 16; endfunction
    function automatic logic [31:0] mask(int sel); return sel == 0 ? 32'hFFFF_FFFF : 32'h0000_FFFF; endfunction
    function automatic logic [31:0] xorout(int sel); return sel == 0 ? 32'hFFFF_FFFF : 32'h0; endfunction
    function automatic logic [31:0] residue(int sel); return sel == 0 ? 32'hDEBB20E3 : 32'h0; endfunction

    // Bit-serial division in transmit order, normal (unreflected) register.
    function automatic logic [31:0] mfeed(logic [31:0] r, int sel, logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            logic bin, top;
            bin = (sel == 0) ? b[k] : b[7-k];
            top = r[wid(sel)-1];
            r   = (r << 1) & mask(sel);
            if (top ^ bin) r = r ^ ((sel == 0) ? 32'h04C11DB7 : 32'h1021);
        end
        return r;
    endfunction

    // Register value as the design holds it (mirrored for the reflected variant).
    function automatic logic [31:0] raw(logic [31:0] r, int sel);
        logic [31:0] o;
        if (sel == 1) return r;
        for (int i = 0; i < 32; i++) o[i] = r[31-i];
        return o;
    endfunction

    task automatic check_outputs();
        for (int k = 0; k < 2; k++) begin
            checks++;
            if (good[k] !== xg[k] || bad[k] !== xb[k]) begin
                failures++;
                $display("FAIL %s dut%0d good,bad actual=%b,%b expected=%b,%b",
                         xtag[k], k, good[k], bad[k], xg[k], xb[k]);
            end
        end
    endtask

    // One clock: check the previous cycle's prediction, drive a beat, predict the next cycle.
    task automatic step(int sel, logic vv, logic ss, logic ee, logic [7:0] dd, string tag);
        @(negedge clk);
        check_outputs();
        for (int k = 0; k < 2; k++) begin
            v[k] = 1'b0; s[k] = 1'b0; e[k] = 1'b0; d[k] = 8'h00;
            xg[k] = 1'b0; xb[k] = 1'b0; xtag[k] = tag;
        end
        if (sel >= 0) begin
            v[sel] = vv; s[sel] = ss; e[sel] = ee; d[sel] = dd;
            if (vv) begin
                if (ss) mreg[sel] = mask(sel);
                mreg[sel] = mfeed(mreg[sel], sel, dd);
                if (ee) begin
                    xg[sel] = (raw(mreg[sel], sel) == residue(sel));
                    xb[sel] = !xg[sel];
                end
            end
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(-1, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    // Payload followed by its check field in the byte order matching the bit order.
    function automatic void build(int sel, logic [7:0] pay[$], output logic [7:0] fr[$]);
        logic [31:0] r, c;
        r = mask(sel);
        fr = pay;
        foreach (pay[i]) r = mfeed(r, sel, pay[i]);
        c = (raw(r, sel) ^ xorout(sel)) & mask(sel);
        if (sel == 0) begin
            for (int i = 0; i < 4; i++) fr.push_back(c[8*i +: 8]);
        end else begin
            fr.push_back(c[15:8]);
            fr.push_back(c[7:0]);
        end
    endfunction

    task automatic send(int sel, logic [7:0] fr[$], logic use_sof, logic expect_good, string tag);
        int n;
        n = fr.size();
        for (int i = 0; i < n; i++) step(sel, 1'b1, use_sof && (i == 0), i == n-1, fr[i], tag);
        checks++;
        if (xg[sel] !== expect_good) begin
            failures++;
            $display("FAIL %s dut%0d predicted good actual=%b expected=%b", tag, sel, xg[sel], expect_good);
        end
    endtask

    initial begin
        logic [7:0] pay[$];
        logic [7:0] fr[$];
        for (int k = 0; k < 2; k++) begin
            v[k] = 0; s[k] = 0; e[k] = 0; d[k] = 0;
            xg[k] = 0; xb[k] = 0; xtag[k] = "R1"; mreg[k] = mask(k);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(2, "R1_reset");

        pay = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        build(0, pay, fr);
        send(0, fr, 1'b0, 1'b1, "R1_no_sof_after_reset");
        idle(2, "R4_pulse_falls");

        send(0, fr, 1'b1, 1'b1, "R2_good_crc32");
        idle(1, "R4_pulse_falls");

        fr[3] = fr[3] ^ 8'h10;
        send(0, fr, 1'b1, 1'b0, "R3_flipped_bit");
        idle(1, "R4_pulse_falls");

        pay = '{8'hA5, 8'h00, 8'hFF, 8'h5A};
        build(0, pay, fr);
        step(0, 1'b1, 1'b1, 1'b0, fr[0], "R6_gap");
        step(0, 1'b0, 1'b1, 1'b1, 8'hEE, "R6_invalid_strobes");
        step(0, 1'b0, 1'b0, 1'b1, 8'h13, "R6_invalid_strobes");
        for (int i = 1; i < fr.size(); i++) begin
            step(0, 1'b1, 1'b0, i == fr.size()-1, fr[i], "R6_gap");
            if (i == 2) step(0, 1'b0, 1'b0, 1'b0, 8'h77, "R6_gap");
        end
        checks++;
        if (xg[0] !== 1'b1) begin failures++; $display("FAIL R6 gapped frame actual=%b expected=1", xg[0]); end
        idle(1, "R6_after");

        step(0, 1'b1, 1'b1, 1'b0, 8'h99, "R5_junk");
        step(0, 1'b1, 1'b0, 1'b0, 8'h42, "R5_junk");
        send(0, fr, 1'b1, 1'b1, "R5_restart");
        send(0, fr, 1'b1, 1'b1, "R4_back_to_back");
        idle(1, "R4_pulse_falls");

        step(0, 1'b1, 1'b1, 1'b1, 8'h00, "R7_single_byte");
        step(0, 1'b1, 1'b1, 1'b1, 8'h6B, "R7_single_byte");
        idle(2, "R7_after");

        pay = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        build(1, pay, fr);
        send(1, fr, 1'b1, 1'b1, "R8_msb_good");
        idle(1, "R8_after");
        fr[fr.size()-1] = fr[fr.size()-1] ^ 8'h01;
        send(1, fr, 1'b1, 1'b0, "R8_msb_bad");
        idle(1, "R8_after");
        pay = '{8'h00, 8'h00, 8'h01};
        build(1, pay, fr);
        send(1, fr, 1'b1, 1'b1, "R8_msb_good2");
        idle(3, "R8_after");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule